// File: doc/BRIEF.md
# Burst Memory Address Capture Unit

This block is the front end of a parallel memory model that supports burst reads. It decides, on every cycle, whether the address presented on the bus is taken into the captured-address register. The array access logic reads that register. The block has three capture paths, and the active one depends on the operation:

- **Level-transparent path.** Used for writes and asynchronous reads. The address flows through while the active-low latch enable is low. It is frozen when latch enable rises.
- **Edge-capture path.** Used for synchronous reads. The address is taken on one selected edge of the memory clock, and only while latch enable is low.
- **Hold.** Chip enable is inactive, so nothing is captured.

Latch enable and the memory clock are not used as clocks. Both are sampled in the single system clock domain, and their edges are detected by comparing each sample with the previous one. The captured address is registered, so it updates on the system clock edge at which the qualifying condition is sampled. Edges are detected only from the second sample after reset, so values held during reset never produce a spurious edge.

Top module: `burst_addr_capture`

## Requirements
- R1: While the active-low reset is low, the captured address is zero on the cycle after each reset edge.
- R2: In an asynchronous read (chip enable low, write enable high, mode bit 0), the captured address equals the address input of the previous cycle while latch enable is low.
- R3: In an asynchronous read, the captured address takes the address sampled in the cycle where latch enable is first seen high after being low. It then holds while latch enable stays high, whatever the address input does.
- R4: In a synchronous read (mode bit 1) with edge-select 0, the address is captured only in a cycle where latch enable is low and the memory clock is seen 1 after being 0. Address changes at other times do not alter the output.
- R5: In a synchronous read with edge-select 1, capture happens only when the memory clock is seen 0 after being 1. A rising memory clock edge does not capture.
- R6: In a synchronous read with latch enable high, memory clock edges do not capture. A latch enable rise in synchronous read also does not capture.
- R7: The memory clock has no effect in asynchronous reads or in writes (write enable low).
- R8: In a write, the address flows through while latch enable is low, and it is captured on the latch enable rise exactly as in R3, independent of the mode bit.
- R9: With chip enable high, the captured address holds its value.
- R10: In the first cycle after reset is released, no edge of latch enable or the memory clock is detected from values present during reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Synchronous active-low reset |
| addr_i | input | ADDR_W | Address bus |
| le_ni | input | 1 | Latch enable, active low (low = transparent) |
| mclk_i | input | 1 | Memory clock, sampled |
| ce_ni | input | 1 | Chip enable, active low |
| we_ni | input | 1 | Write enable, active low |
| sync_mode_i | input | 1 | 1 = synchronous read, 0 = asynchronous read |
| edge_sel_i | input | 1 | Memory clock capture edge: 0 rising, 1 falling |
| addr_o | output | ADDR_W | Captured address |

## Verification
The bench builds the block with the default 16-bit address. This width is wide enough that the distinct directed patterns cannot alias, including all-ones and alternating-bit values. Because the memory clock and latch enable are driven as slow sampled signals, every combination of edge, level, mode and operation can be placed in a chosen cycle. This includes an edge that coincides with a reset release or with a latch enable change. A behavioural model tracks the expected address and is compared on every clock, alongside directed checks of fixed values.

// File: rtl/bac_pkg.sv
// Package: shared operation type for the burst address capture unit.
package bac_pkg;
    // Operation that selects which capture path is active.
    typedef enum logic [1:0] {
        OP_IDLE    = 2'd0,
        OP_WRITE   = 2'd1,
        OP_ASYNC_RD = 2'd2,
        OP_SYNC_RD = 2'd3
    } bac_op_e;
endpackage

// File: rtl/bac_edge_sampler.sv
// Samples a vector of slow control signals in the system clock domain.
// Each bit's previous sample is exposed so the caller can detect edges.
// Assumes: inputs are already synchronous to clk_i. After reset the
// previous samples are not trusted until valid_o rises (one cycle).
module bac_edge_sampler #(
    parameter int               W         = 2,
    parameter logic [W-1:0]     RESET_VAL = '0
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic [W-1:0] sig_i,
    output logic [W-1:0] prev_o,
    output logic         valid_o
);
    generate
        for (genvar i = 0; i < W; i++) begin : g_bit
            // Holds last cycle's sample of bit i.
            always_ff @(posedge clk_i) begin
                if (!rst_ni) prev_o[i] <= RESET_VAL[i];
                else         prev_o[i] <= sig_i[i];
            end
        end
    endgenerate

    // Marks that prev_o holds a post-reset sample.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) valid_o <= 1'b0;
        else         valid_o <= 1'b1;
    end
endmodule

// File: rtl/bac_op_decode.sv
// Decodes chip enable, write enable and mode bit into the operation.
// Assumes: active-low enables; a write overrides the read mode bit.
module bac_op_decode
    import bac_pkg::*;
(
    input  logic    ce_ni,
    input  logic    we_ni,
    input  logic    sync_mode_i,
    output bac_op_e op_o
);
    // Priority: chip disabled, then write, then read mode.
    always_comb begin
        if (ce_ni)            op_o = OP_IDLE;
        else if (!we_ni)      op_o = OP_WRITE;
        else if (sync_mode_i) op_o = OP_SYNC_RD;
        else                  op_o = OP_ASYNC_RD;
    end
endmodule

// File: rtl/bac_capture_reg.sv
// Captured-address register with per-operation load selection.
// Level path: transparent while latch enable low, load on its rise.
// Edge path: load on the selected memory clock edge while latch low.
// Assumes: edge strobes are single-cycle and already qualified.
module bac_capture_reg
    import bac_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  bac_op_e           op_i,
    input  logic              le_low_i,
    input  logic              le_rise_i,
    input  logic              mclk_edge_i,
    input  logic [ADDR_W-1:0] addr_i,
    output logic [ADDR_W-1:0] addr_o
);
    logic load;

    // Chooses the active capture path from the operation.
    always_comb begin
        unique case (op_i)
            OP_WRITE,
            OP_ASYNC_RD: load = le_low_i | le_rise_i;
            OP_SYNC_RD:  load = le_low_i & mclk_edge_i;
            default:     load = 1'b0;
        endcase
    end

    // Holds the captured address; zero on reset.
    always_ff @(posedge clk_i) begin
        if (!rst_ni)   addr_o <= '0;
        else if (load) addr_o <= addr_i;
    end
endmodule

// File: rtl/burst_addr_capture.sv
// Top of the address capture unit. Samples latch enable and the memory
// clock, forms edge strobes, decodes the operation and drives the
// captured-address register.
// Assumes: all inputs synchronous to clk_i; latch enable is held high
// during power-up and reset.
module burst_addr_capture
    import bac_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              le_ni,
    input  logic              mclk_i,
    input  logic              ce_ni,
    input  logic              we_ni,
    input  logic              sync_mode_i,
    input  logic              edge_sel_i,
    output logic [ADDR_W-1:0] addr_o
);
    localparam int              NUM_SMP  = 2;
    localparam int              IDX_LE   = 0;
    localparam int              IDX_MCLK = 1;
    localparam logic [NUM_SMP-1:0] SMP_RST = 2'b01; // latch high, clock low

    logic [NUM_SMP-1:0] smp_now;
    logic [NUM_SMP-1:0] smp_prev;
    logic               smp_valid;
    logic               le_rise;
    logic               mclk_edge;
    bac_op_e            op;

    assign smp_now[IDX_LE]   = le_ni;
    assign smp_now[IDX_MCLK] = mclk_i;

    bac_edge_sampler #(
        .W         (NUM_SMP),
        .RESET_VAL (SMP_RST)
    ) u_sampler (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .sig_i   (smp_now),
        .prev_o  (smp_prev),
        .valid_o (smp_valid)
    );

    // Forms qualified latch-rise and selected memory-clock-edge strobes.
    always_comb begin
        le_rise = smp_valid & le_ni & ~smp_prev[IDX_LE];
        if (edge_sel_i) mclk_edge = smp_valid & ~mclk_i & smp_prev[IDX_MCLK];
        else            mclk_edge = smp_valid & mclk_i & ~smp_prev[IDX_MCLK];
    end

    bac_op_decode u_decode (
        .ce_ni       (ce_ni),
        .we_ni       (we_ni),
        .sync_mode_i (sync_mode_i),
        .op_o        (op)
    );

    bac_capture_reg #(
        .ADDR_W (ADDR_W)
    ) u_capture (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .op_i        (op),
        .le_low_i    (~le_ni),
        .le_rise_i   (le_rise),
        .mclk_edge_i (mclk_edge),
        .addr_i      (addr_i),
        .addr_o      (addr_o)
    );
endmodule

// File: rtl/bac_checker.sv
// Port-level assertions for burst_addr_capture, attached by bind.
// Assumes: the same clock and reset as the unit it observes.
module bac_checker #(
    parameter int ADDR_W = 16
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic [ADDR_W-1:0] addr_i,
    input logic              le_ni,
    input logic              ce_ni,
    input logic              we_ni,
    input logic              sync_mode_i,
    input logic [ADDR_W-1:0] addr_o
);
    // R1: reset clears the captured address.
    p_reset_zero_r1: assert property (@(posedge clk_i)
        !rst_ni |=> (addr_o == '0));

    // R2 / R8: transparent path follows the previous cycle's address.
    p_transparent_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!ce_ni && !le_ni && (!we_ni || !sync_mode_i)) |=> (addr_o == $past(addr_i)));

    // R3: latch enable held high keeps the asynchronous read value.
    p_le_high_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!ce_ni && we_ni && !sync_mode_i && le_ni && $past(le_ni) && $past(rst_ni))
        |=> $stable(addr_o));

    // R6: synchronous read with latch enable high never captures.
    p_sync_le_high_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!ce_ni && we_ni && sync_mode_i && le_ni) |=> $stable(addr_o));

    // R9: chip disabled holds the value.
    p_ce_off_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ce_ni |=> $stable(addr_o));
endmodule

bind burst_addr_capture bac_checker #(.ADDR_W(ADDR_W)) u_bac_checker (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .addr_i      (addr_i),
    .le_ni       (le_ni),
    .ce_ni       (ce_ni),
    .we_ni       (we_ni),
    .sync_mode_i (sync_mode_i),
    .addr_o      (addr_o)
);

// File: tb/burst_addr_capture_tb_top.sv
// Self-checking bench: behavioural reference compared on every clock,
// plus directed checks of fixed expected values.
module burst_addr_capture_tb_top;
    localparam int AW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] addr = '0;
    logic          le_n = 1'b1;
    logic          mclk = 1'b0;
    logic          ce_n = 1'b1;
    logic          we_n = 1'b1;
    logic          sync_m = 1'b0;
    logic          esel = 1'b0;
    logic [AW-1:0] addr_out;

    int    n_cmp = 0;
    int    n_bad = 0;
    string cur_req = "R1";
    bit    done = 1'b0;

    // Reference state.
    int    exp_addr = 0;
    int    ref_le_prev = 1;
    int    ref_mk_prev = 0;
    bit    ref_seen = 1'b0;

    always #2 clk = ~clk; // 250 MHz

    burst_addr_capture #(.ADDR_W(AW)) dut_i (
        .clk_i (clk), .rst_ni (rst_n), .addr_i (addr), .le_ni (le_n),
        .mclk_i (mclk), .ce_ni (ce_n), .we_ni (we_n),
        .sync_mode_i (sync_m), .edge_sel_i (esel), .addr_o (addr_out)
    );

    // Behavioural model of the capture rules, evaluated at each edge.
    always @(posedge clk) begin
        bit take;
        bit le_up;
        bit mk_hit;
        if (!rst_n) begin
            exp_addr = 0; ref_le_prev = 1; ref_mk_prev = 0; ref_seen = 0;
        end else begin
            le_up  = ref_seen && le_n && (ref_le_prev == 0);
            mk_hit = ref_seen && (esel ? (!mclk && ref_mk_prev == 1)
                                       : (mclk && ref_mk_prev == 0));
            take = 0;
            if (!ce_n) begin
                if (!we_n || !sync_m) take = !le_n || le_up;
                else                  take = !le_n && mk_hit;
            end
            if (take) exp_addr = int'(addr);
            ref_le_prev = le_n; ref_mk_prev = mclk; ref_seen = 1;
        end
    end

    task automatic check(input logic [AW-1:0] exp, input string req);
        n_cmp++;
        if (addr_out !== exp) begin
            n_bad++;
            $display("FAIL %s: addr_o=%h expected=%h at %0t", req, addr_out, exp, $time);
        end
    endtask

    // Compare against the model away from the active edge.
    always @(negedge clk) begin
        if (!done) check(AW'(exp_addr), cur_req);
    end

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        #(4 * 5000);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: expired, expected completion");
        finish_run();
    end

    initial begin
        // R1: reset value
        cur_req = "R1";
        cyc(3);
        check('0, "R1");

        // R10: release with latch low and memory clock high in sync read
        cur_req = "R10";
        ce_n = 0; we_n = 1; sync_m = 1; esel = 0; le_n = 0; mclk = 1;
        addr = 16'hBEEF;
        rst_n = 1;
        cyc(1);
        check('0, "R10");
        mclk = 0; le_n = 1; cyc(1);

        // R2: async read transparency
        cur_req = "R2";
        sync_m = 0; le_n = 0; addr = 16'h00A1; cyc(1);
        check(16'h00A1, "R2");
        addr = 16'hAAAA; cyc(1);
        check(16'hAAAA, "R2");

        // R3: capture on latch rise, then hold
        cur_req = "R3";
        addr = 16'h1234; le_n = 1; cyc(1);
        check(16'h1234, "R3");
        addr = 16'hFFFF; cyc(3);
        check(16'h1234, "R3");

        // R7: memory clock toggles ignored in async read
        cur_req = "R7";
        for (int i = 0; i < 4; i++) begin mclk = ~mclk; cyc(1); end
        check(16'h1234, "R7");
        le_n = 0; addr = 16'h0F0F; mclk = 1; cyc(1);
        check(16'h0F0F, "R7");
        mclk = 0; cyc(1);
        le_n = 1; cyc(1);

        // R4: sync read, rising edge capture only
        cur_req = "R4";
        sync_m = 1; esel = 0; le_n = 0; addr = 16'h0ABC; cyc(2);
        check(16'h0F0F, "R4");
        mclk = 1; cyc(1);
        check(16'h0ABC, "R4");
        addr = 16'h0DEF; cyc(1);
        check(16'h0ABC, "R4");
        mclk = 0; cyc(1);
        check(16'h0ABC, "R4");

        // R5: falling edge select
        cur_req = "R5";
        esel = 1; addr = 16'h5555; mclk = 1; cyc(1);
        check(16'h0ABC, "R5");
        mclk = 0; cyc(1);
        check(16'h5555, "R5");

        // R6: latch high blocks edges; latch rise does not capture
        cur_req = "R6";
        addr = 16'h7777; le_n = 1; cyc(1);
        check(16'h5555, "R6");
        for (int i = 0; i < 4; i++) begin mclk = ~mclk; cyc(1); end
        check(16'h5555, "R6");

        // R8: write flow-through and rise capture, mode bit still 1
        cur_req = "R8";
        we_n = 0; le_n = 0; addr = 16'h2468; cyc(1);
        check(16'h2468, "R8");
        addr = 16'h1357; le_n = 1; cyc(1);
        check(16'h1357, "R8");
        addr = 16'h0000; mclk = 1; cyc(1); mclk = 0; cyc(1);
        check(16'h1357, "R7");

        // R9: chip disabled holds
        cur_req = "R9";
        ce_n = 1; le_n = 0; addr = 16'h9999; cyc(2);
        check(16'h1357, "R9");
        le_n = 1; mclk = 1; cyc(2);
        check(16'h1357, "R9");

        // R1: reset mid-run clears
        cur_req = "R1";
        rst_n = 0; cyc(2);
        check('0, "R1");
        rst_n = 1; cyc(2);

        finish_run();
    end
endmodule